// File: doc/BRIEF.md
# SPI Slave with Data-Ready Request

This block is the device side of a four-wire serial link with a single controller. The controller owns the serial clock and the chip select. The slave only shifts data while it is selected, and only on clock edges the controller produces. It cannot start a transfer. When user logic has a byte to hand over, the block raises a dedicated `data_ready_o` line. The controller can use that line as an interrupt and then open a transfer.

Each selected transfer is a run of 8-bit full-duplex frames, MSB first, in clock mode 0. In the opening frame the command byte arrives. At the same time the slave sends a status byte, because it does not yet know the command. In the second frame the slave sends the answer to that command and throws away the dummy byte the controller clocks in. Any later frames in the same selection carry a fixed filler value. The framing depends only on chip select, so a clock that keeps running while the slave is deselected has no effect.

All serial inputs pass through a two-flop synchroniser into the system clock domain, where all the logic runs. The received command reaches user logic as a one-cycle strobe together with the byte.

Top module: `spis_dready_slave`

## Requirements
- R1: While chip select is high (inactive), `miso_oe_o` is low, and clock pulses neither shift data nor move the bit position. The next selection starts again from bit 7 of the status byte.
- R2: Mode 0, MSB first. MOSI is taken on the rising clock edge and MISO changes only after a falling edge or a chip-select assertion. Every 8 rising edges complete one byte in each direction.
- R3: The first frame after chip select falls returns the status byte. Bits 7..1 are `stat_bits_i[6:0]` and bit 0 is the data-pending flag, equal to `data_ready_o` at the moment of selection.
- R4: If the command byte is 0x01 and data is pending, the second frame returns the loaded data byte.
- R5: For any other command, or for 0x01 with nothing pending, the second frame returns the filler value (parameter `FILL`, default 0xFF). Every frame after the second also returns the filler.
- R6: The byte received during the second and later frames is ignored. It produces no command strobe, and a different dummy byte does not change the reply.
- R7: A cycle with `ld_valid_i` high stores `ld_data_i` and sets `data_ready_o` in the next cycle.
- R8: `data_ready_o` clears only after the 8th rising edge of a second frame that carried the data byte. If chip select is released before that edge, the flag stays set.
- R9: A load that arrives after the command has been taken keeps the new byte pending, even after the reply frame completes.
- R10: Each selection that completes a first frame pulses `cmd_valid_o` for exactly one system clock, with the received command on `cmd_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| ld_valid_i | input | 1 | Load strobe for the pending data byte |
| ld_data_i | input | 8 | Data byte to hand to the controller |
| stat_bits_i | input | 7 | User status bits, sent in bits 7..1 of the status byte |
| cmd_valid_o | output | 1 | One-cycle strobe: a command byte was received |
| cmd_data_o | output | 8 | Last received command byte |
| data_ready_o | output | 1 | Request line to the controller: data is pending |

## Verification
The hardest states to reach are the ones where the pending flag's fate depends on precisely where a transfer stops. These are a reply frame cut off by chip select after a few bits, and a fresh load that lands inside the reply frame after the old byte has already been latched for shifting. The bench drives the controller at bit granularity so it can release chip select or pulse the load port between two chosen clock edges. It then opens a follow-up transfer and reads the status byte and the reply to see which byte survived. A free-running clock burst while deselected is followed at once by a normal transfer, which shows that the framing did not move.

// File: rtl/spis_pkg.sv
package spis_pkg;

  // Position of a frame inside one chip-select window
  typedef enum logic [1:0] {
    FR_STATUS = 2'd0,
    FR_REPLY  = 2'd1,
    FR_TAIL   = 2'd2
  } frame_e;

endpackage

// File: rtl/spis_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs
module spis_sync #(
  parameter int unsigned         W       = 1,
  parameter int unsigned         STAGES  = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spis_edge.sv
// Edge detection on the synchronised serial clock and chip select
module spis_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic csn_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_start,
  output logic cs_act
);

  logic sck_q;
  logic csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
    end
  end

  assign cs_act   = ~csn_s;
  assign cs_start = ~csn_s & csn_q;
  // Edges count only inside a selection; a free-running clock is masked
  assign sck_rise = cs_act & ~cs_start & sck_s & ~sck_q;
  assign sck_fall = cs_act & ~cs_start & ~sck_s & sck_q;

endmodule

// File: rtl/spis_shifter.sv
// Bit counter plus receive and transmit shift registers
module spis_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_start,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] first_byte,
  input  logic [DATA_W-1:0] next_byte,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_word,
  output logic              tx_bit
);

  localparam int unsigned        CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0]   LAST  = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q,    cnt_d;
  logic [DATA_W-1:0] rx_q,     rx_d;
  logic [DATA_W-1:0] tx_q,     tx_d;
  logic              reload_q, reload_d;
  logic              last_bit;

  assign last_bit  = (cnt_q == LAST);
  assign byte_done = sck_rise & last_bit;
  assign rx_word   = {rx_q[DATA_W-2:0], mosi_s};
  assign tx_bit    = tx_q[DATA_W-1];

  always_comb begin
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    reload_d = reload_q;
    if (cs_start) begin
      cnt_d    = '0;
      tx_d     = first_byte;
      reload_d = 1'b0;
    end else if (sck_rise) begin
      rx_d = rx_word;
      if (last_bit) begin
        cnt_d    = '0;
        reload_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (sck_fall) begin
      if (reload_q) begin
        tx_d     = next_byte;
        reload_d = 1'b0;
      end else begin
        tx_d = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      reload_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      reload_q <= reload_d;
    end
  end

endmodule

// File: rtl/spis_ctrl.sv
// Frame sequencing, pending-data flag and command hand-off
module spis_ctrl
  import spis_pkg::*;
#(
  parameter int unsigned        DATA_W    = 8,
  parameter logic [DATA_W-1:0]  FILL      = '1,
  parameter logic [DATA_W-1:0]  CMD_FETCH = DATA_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_start,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [DATA_W-2:0] stat_bits,
  output logic [DATA_W-1:0] first_byte,
  output logic [DATA_W-1:0] next_byte,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  output logic              data_ready
);

  frame_e            frame_q,  frame_d;
  logic [DATA_W-1:0] reply_q,  reply_d;
  logic [DATA_W-1:0] data_q,   data_d;
  logic              pend_q,   pend_d;
  logic              carry_q,  carry_d;
  logic              cvld_q,   cvld_d;
  logic [DATA_W-1:0] cmd_q,    cmd_d;

  assign first_byte = {stat_bits, pend_q};
  assign next_byte  = (frame_q == FR_REPLY) ? reply_q : FILL;
  assign cmd_valid  = cvld_q;
  assign cmd_data   = cmd_q;
  assign data_ready = pend_q;

  always_comb begin
    frame_d = frame_q;
    reply_d = reply_q;
    data_d  = data_q;
    pend_d  = pend_q;
    carry_d = carry_q;
    cvld_d  = 1'b0;
    cmd_d   = cmd_q;

    if (cs_start) begin
      frame_d = FR_STATUS;
      carry_d = 1'b0;
    end else if (byte_done) begin
      unique case (frame_q)
        FR_STATUS: begin
          frame_d = FR_REPLY;
          cmd_d   = rx_word;
          cvld_d  = 1'b1;
          if ((rx_word == CMD_FETCH) && pend_q) begin
            reply_d = data_q;
            carry_d = 1'b1;
          end else begin
            reply_d = FILL;
            carry_d = 1'b0;
          end
        end
        FR_REPLY: begin
          frame_d = FR_TAIL;
          if (carry_q) pend_d = 1'b0;
          carry_d = 1'b0;
        end
        default: frame_d = FR_TAIL;
      endcase
    end

    // A fresh load always wins: the new byte stays pending
    if (ld_valid) begin
      data_d  = ld_data;
      pend_d  = 1'b1;
      carry_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= FR_STATUS;
      reply_q <= '0;
      data_q  <= '0;
      pend_q  <= 1'b0;
      carry_q <= 1'b0;
      cvld_q  <= 1'b0;
      cmd_q   <= '0;
    end else begin
      frame_q <= frame_d;
      reply_q <= reply_d;
      data_q  <= data_d;
      pend_q  <= pend_d;
      carry_q <= carry_d;
      cvld_q  <= cvld_d;
      cmd_q   <= cmd_d;
    end
  end

endmodule

// File: rtl/spis_dready_slave.sv
module spis_dready_slave #(
  parameter int unsigned        DATA_W      = 8,
  parameter int unsigned        SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0]  FILL        = '1,
  parameter logic [DATA_W-1:0]  CMD_FETCH   = DATA_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              ld_valid_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [DATA_W-2:0] stat_bits_i,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              data_ready_o
);

  logic              sck_s, csn_s, mosi_s;
  logic              sck_rise, sck_fall, cs_start, cs_act;
  logic              byte_done;
  logic [DATA_W-1:0] rx_word, first_byte, next_byte;

  spis_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_i, csn_i, mosi_i}),
    .q     ({sck_s, csn_s, mosi_s})
  );

  spis_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .csn_s    (csn_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_start (cs_start),
    .cs_act   (cs_act)
  );

  spis_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_start   (cs_start),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .mosi_s     (mosi_s),
    .first_byte (first_byte),
    .next_byte  (next_byte),
    .byte_done  (byte_done),
    .rx_word    (rx_word),
    .tx_bit     (miso_o)
  );

  spis_ctrl #(
    .DATA_W    (DATA_W),
    .FILL      (FILL),
    .CMD_FETCH (CMD_FETCH)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_start   (cs_start),
    .byte_done  (byte_done),
    .rx_word    (rx_word),
    .ld_valid   (ld_valid_i),
    .ld_data    (ld_data_i),
    .stat_bits  (stat_bits_i),
    .first_byte (first_byte),
    .next_byte  (next_byte),
    .cmd_valid  (cmd_valid_o),
    .cmd_data   (cmd_data_o),
    .data_ready (data_ready_o)
  );

  assign miso_oe_o = cs_act;

endmodule

// File: rtl/spis_dready_chk.sv
module spis_dready_chk (
  input logic clk,
  input logic rst_n,
  input logic csn_i,
  input logic ld_valid_i,
  input logic miso_o,
  input logic miso_oe_o,
  input logic cmd_valid_o,
  input logic data_ready_o,
  input logic sck_rise,
  input logic sck_fall,
  input logic cs_start
);

  // R1: a chip select held inactive for several cycles keeps the pad off
  p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !miso_oe_o);

  // R2: MISO moves only after a falling edge or a new selection
  p_miso_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_start) |=> $stable(miso_o));

  // R7: a load raises the request line one cycle later
  p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_i |=> data_ready_o);

  // R8: the request line drops only right after a rising serial edge
  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready_o) |-> $past(sck_rise));

  // R10: the command strobe lasts a single cycle
  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

endmodule

bind spis_dready_slave spis_dready_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csn_i        (csn_i),
  .ld_valid_i   (ld_valid_i),
  .miso_o       (miso_o),
  .miso_oe_o    (miso_oe_o),
  .cmd_valid_o  (cmd_valid_o),
  .data_ready_o (data_ready_o),
  .sck_rise     (sck_rise),
  .sck_fall     (sck_fall),
  .cs_start     (cs_start)
);

// File: tb/tb_spis_dready_slave.sv
`timescale 1ns/1ps
module tb_spis_dready_slave;

  localparam int HALF = 8;   // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso_o, miso_oe_o;
  logic       ld_valid = 1'b0;
  logic [7:0] ld_data = '0;
  logic [6:0] stat_bits = 7'h55;
  logic       cmd_valid_o, data_ready_o;
  logic [7:0] cmd_data_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  spis_dready_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .ld_valid_i(ld_valid),
    .ld_data_i(ld_data), .stat_bits_i(stat_bits), .cmd_valid_o(cmd_valid_o),
    .cmd_data_o(cmd_data_o), .data_ready_o(data_ready_o)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Controller bit engine: drive on the low phase, sample MISO before rising
  task automatic shift_bits(input logic [7:0] tx, input int msb, input int lsb,
                            inout logic [7:0] rx);
    for (int i = msb; i >= lsb; i--) begin
      mosi = tx[i];
      wait_n(HALF);
      rx[i] = miso_o;
      sclk = 1'b1;
      wait_n(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r;
    r = '0;
    shift_bits(tx, 7, 0, r);
    rx = r;
  endtask

  // Driver: selection plus command frame; expected strobe goes to the scoreboard
  task automatic open_cmd(input logic [7:0] cmd, output logic [7:0] status);
    csn = 1'b0;
    wait_n(HALF);
    exp_q.push_back(cmd);
    xfer(cmd, status);
  endtask

  task automatic close_sel();
    wait_n(4);
    csn = 1'b1;
    wait_n(HALF);
  endtask

  task automatic load(input logic [7:0] d);
    ld_data  = d;
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R7", "ready after load", {7'd0, data_ready_o}, 8'h01);
  endtask

  // Monitor: every strobe must match the next queued command
  always @(negedge clk) begin
    if (rst_n && cmd_valid_o) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10/R6 unexpected strobe: actual %h expected none", cmd_data_o);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (cmd_data_o !== e) begin
          n_fail++;
          $display("FAIL R10 command byte: actual %h expected %h", cmd_data_o, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] st, rp, tl;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);

    // Reset state
    check("R1", "oe after reset", {7'd0, miso_oe_o}, 8'h00);
    check("R8", "ready after reset", {7'd0, data_ready_o}, 8'h00);
    check("R10", "strobe after reset", {7'd0, cmd_valid_o}, 8'h00);

    // Fetch with nothing pending: status 0xAA, filler reply
    open_cmd(8'h01, st);
    check("R1", "oe while selected", {7'd0, miso_oe_o}, 8'h01);
    xfer(8'h5A, rp);
    close_sel();
    check("R3", "status no pending", st, 8'hAA);
    check("R5", "fetch with nothing pending", rp, 8'hFF);

    load(8'h3C);

    // Other command with data pending: filler reply and tail, flag kept
    open_cmd(8'h7E, st);
    xfer(8'h00, rp);
    xfer(8'h00, tl);
    close_sel();
    check("R3", "status pending", st, 8'hAB);
    check("R5", "reply to other command", rp, 8'hFF);
    check("R5", "tail frame", tl, 8'hFF);
    check("R8", "ready kept after other cmd", {7'd0, data_ready_o}, 8'h01);

    // Free-running clock while deselected
    for (int k = 0; k < 12; k++) begin
      mosi = k[0];
      wait_n(HALF); sclk = 1'b1;
      check("R1", "oe with clock while deselected", {7'd0, miso_oe_o}, 8'h00);
      wait_n(HALF); sclk = 1'b0;
    end

    // Reply frame cut after four bits: flag must stay
    open_cmd(8'h01, st);
    check("R1", "framing after free clock", st, 8'hAB);
    rp = '0;
    shift_bits(8'h00, 7, 4, rp);
    close_sel();
    check("R4", "upper nibble of cut reply", {4'h0, rp[7:4]}, 8'h03);
    check("R8", "ready kept after abort", {7'd0, data_ready_o}, 8'h01);

    // Full fetch with dummy 0xA5: data returned, flag cleared, no extra strobe
    open_cmd(8'h01, st);
    xfer(8'hA5, rp);
    check("R8", "ready cleared after reply", {7'd0, data_ready_o}, 8'h00);
    xfer(8'h00, tl);
    close_sel();
    check("R3", "status before fetch", st, 8'hAB);
    check("R4", "fetched data", rp, 8'h3C);
    check("R6", "tail after dummy", tl, 8'hFF);

    // R9: load lands inside the reply frame
    load(8'h96);
    open_cmd(8'h01, st);
    rp = '0;
    shift_bits(8'h00, 7, 5, rp);
    load(8'hC3);
    shift_bits(8'h00, 4, 0, rp);
    close_sel();
    check("R9", "reply uses latched byte", rp, 8'h96);
    check("R9", "new byte still pending", {7'd0, data_ready_o}, 8'h01);
    open_cmd(8'h01, st);
    xfer(8'h00, rp);
    close_sel();
    check("R9", "new byte fetched", rp, 8'hC3);
    check("R8", "ready cleared", {7'd0, data_ready_o}, 8'h00);

    // Other status bits, nothing pending
    stat_bits = 7'h0F;
    open_cmd(8'h22, st);
    xfer(8'hFF, rp);
    close_sel();
    check("R3", "status from user bits", st, 8'h1E);
    check("R5", "reply to unknown command", rp, 8'hFF);

    wait_n(10);
    check("R10", "all commands strobed", 8'(exp_q.size()), 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule